// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block walks a two-level translation table for one 32-bit virtual address at a time. It takes a virtual address and a translation table base. From these it forms the address of the first-level descriptor and issues a single-word read on its memory port. It then decodes the word that comes back.

The two low bits of that word select what happens next. A section entry finishes the walk with a physical address and the attributes of that section. A coarse-table entry starts a second read inside a 256-entry table, where each entry covers 4 KB of the 1 MB region. The raw second-level word is then handed on, with the domain, to a later stage that decodes it. The two remaining codes finish the walk with a fault.

The walker accepts a new address only while it is idle. It pulses a done strobe when the result outputs hold a finished walk.

Top module: `ttw_walker`

## Requirements
- R1: The first memory request of a walk carries the address {ttb[31:14], va[31:20], 2'b00}.
- R2: A first-level word with bits [1:0] = 2'b10 ends the walk after that one fetch with res_kind_o = 2'b00 (section) and pa_o = {desc[31:20], va[19:0]}.
- R3: On a section result, ap_o = desc[11:10], dom_o = desc[8:5] and attr_o = desc[3:2].
- R4: A first-level word with bits [1:0] = 2'b01 causes a second request at address {desc[31:10], va[19:12], 2'b00}.
- R5: After the second response, the walk ends with res_kind_o = 2'b01 (page), l2_desc_o equal to the returned word, and dom_o equal to bits [8:5] of the first-level word.
- R6: A first-level type of 2'b00 ends the walk with res_kind_o = 2'b10 (fault) and fault_code_o = 0 (translation fault). A type of 2'b11 does the same with fault_code_o = 1 (unsupported descriptor). In both cases fault_va_o equals the walked address and no second request is made.
- R7: mem_req_valid_o stays high with a stable mem_addr_o until mem_req_ready_i is seen. The request stays low while the walker waits for a response.
- R8: req_ready_o is high only while idle. A req_valid_i during a walk is ignored, and the result reflects the address that was accepted.
- R9: done_o is high for exactly one cycle per walk, and the walker is ready again on the next cycle.
- R10: An active-low asynchronous reset returns the walker to idle at once, with no memory request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Walk request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| va_i | input | 32 | Virtual address to translate |
| ttb_i | input | 32 | Translation table base |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_addr_o | output | 32 | Word address of the descriptor read |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle walk completion strobe |
| res_kind_o | output | 2 | 0 section, 1 page descriptor, 2 fault |
| pa_o | output | 32 | Physical address (section) |
| ap_o | output | 2 | Access permissions (section) |
| dom_o | output | 4 | Domain number (section or page) |
| attr_o | output | 2 | Cacheable/bufferable attributes (section) |
| l2_desc_o | output | 32 | Raw second-level word (page) |
| fault_code_o | output | 1 | 0 translation fault, 1 unsupported descriptor |
| fault_va_o | output | 32 | Virtual address of the walk |

## Verification
The checker watches the properties that hold in every cycle. It checks the first-level request address against the address that was accepted, and it checks that a request holds while the memory stalls and never overlaps a pending response. It also checks that the done strobe lasts one cycle, that the ready signal and a walk never coexist, and that a section or fault result carries the accepted address. Only the bench scenarios can show the decode of each descriptor type and the second-level address built from the returned base. They also cover intruding requests during a walk and a reset taken in mid-walk, using random descriptors, latencies and stalls mixed with directed edge values.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    DT_FAULT   = 2'b00,
    DT_COARSE  = 2'b01,
    DT_SECTION = 2'b10,
    DT_RSVD    = 2'b11
  } desc_type_e;

  typedef enum logic [1:0] {
    RK_SECTION = 2'd0,
    RK_PAGE    = 2'd1,
    RK_FAULT   = 2'd2
  } res_kind_e;
endpackage

// File: rtl/ttw_addr_gen.sv
module ttw_addr_gen #(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8
) (
  input  logic [VA_W-1:0]            va_i,
  input  logic [VA_W-1:0]            ttb_i,
  input  logic [VA_W-L2_IDX_W-3:0]   cbase_i,
  input  logic                       sel_l2_i,
  output logic [VA_W-1:0]            addr_o
);
  localparam int OFF_W = VA_W - L1_IDX_W;
  localparam int TTB_W = VA_W - L1_IDX_W - 2;

  logic [VA_W-1:0] l1_addr, l2_addr;

  assign l1_addr = {ttb_i[VA_W-1 -: TTB_W], va_i[VA_W-1 -: L1_IDX_W], 2'b00};
  assign l2_addr = {cbase_i, va_i[OFF_W-1 -: L2_IDX_W], 2'b00};
  assign addr_o  = sel_l2_i ? l2_addr : l1_addr;
endmodule

// File: rtl/ttw_l1_decode.sv
module ttw_l1_decode
  import ttw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8
) (
  input  logic [VA_W-1:0]          desc_i,
  input  logic [VA_W-1:0]          va_i,
  output desc_type_e               typ_o,
  output logic [VA_W-1:0]          sec_pa_o,
  output logic [1:0]               ap_o,
  output logic [3:0]               dom_o,
  output logic [1:0]               attr_o,
  output logic [VA_W-L2_IDX_W-3:0] cbase_o
);
  localparam int OFF_W = VA_W - L1_IDX_W;
  localparam int CB_W  = VA_W - L2_IDX_W - 2;

  assign typ_o    = desc_type_e'(desc_i[1:0]);
  assign sec_pa_o = {desc_i[VA_W-1 -: L1_IDX_W], va_i[OFF_W-1:0]};
  assign ap_o     = desc_i[11:10];
  assign dom_o    = desc_i[8:5];
  assign attr_o   = desc_i[3:2];
  assign cbase_o  = desc_i[VA_W-1 -: CB_W];
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker
  import ttw_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] va_i,
  input  logic [VA_W-1:0] ttb_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [VA_W-1:0] mem_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [VA_W-1:0] mem_rdata_i,
  output logic            done_o,
  output logic [1:0]      res_kind_o,
  output logic [VA_W-1:0] pa_o,
  output logic [1:0]      ap_o,
  output logic [3:0]      dom_o,
  output logic [1:0]      attr_o,
  output logic [VA_W-1:0] l2_desc_o,
  output logic            fault_code_o,
  output logic [VA_W-1:0] fault_va_o
);
  localparam int CB_W = VA_W - L2_IDX_W - 2;

  walk_st_e        st_q;
  logic [VA_W-1:0] va_q, ttb_q;
  logic [CB_W-1:0] cbase_q;

  desc_type_e      d_typ;
  logic [VA_W-1:0] d_pa;
  logic [1:0]      d_ap, d_attr;
  logic [3:0]      d_dom;
  logic [CB_W-1:0] d_cbase;

  ttw_addr_gen #(.VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)) u_addr (
    .va_i     (va_q),
    .ttb_i    (ttb_q),
    .cbase_i  (cbase_q),
    .sel_l2_i (st_q == ST_L2_REQ),
    .addr_o   (mem_addr_o)
  );

  ttw_l1_decode #(.VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)) u_dec (
    .desc_i   (mem_rdata_i),
    .va_i     (va_q),
    .typ_o    (d_typ),
    .sec_pa_o (d_pa),
    .ap_o     (d_ap),
    .dom_o    (d_dom),
    .attr_o   (d_attr),
    .cbase_o  (d_cbase)
  );

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
  assign done_o          = (st_q == ST_DONE);
  assign fault_va_o      = va_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      va_q         <= '0;
      ttb_q        <= '0;
      cbase_q      <= '0;
      res_kind_o   <= RK_SECTION;
      pa_o         <= '0;
      ap_o         <= '0;
      dom_o        <= '0;
      attr_o       <= '0;
      l2_desc_o    <= '0;
      fault_code_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q  <= va_i;
          ttb_q <= ttb_i;
          pa_o  <= '0;
          st_q  <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_req_ready_i) st_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid_i) begin
          unique case (d_typ)
            DT_SECTION: begin
              res_kind_o <= RK_SECTION;
              pa_o       <= d_pa;
              ap_o       <= d_ap;
              dom_o      <= d_dom;
              attr_o     <= d_attr;
              st_q       <= ST_DONE;
            end
            DT_COARSE: begin
              cbase_q <= d_cbase;
              dom_o   <= d_dom;
              st_q    <= ST_L2_REQ;
            end
            default: begin
              res_kind_o   <= RK_FAULT;
              fault_code_o <= (d_typ == DT_RSVD);
              st_q         <= ST_DONE;
            end
          endcase
        end
        ST_L2_REQ: if (mem_req_ready_i) st_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid_i) begin
          res_kind_o <= RK_PAGE;
          l2_desc_o  <= mem_rdata_i;
          st_q       <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ttw_walker_chk.sv
module ttw_walker_chk #(
  parameter int VA_W     = 32,
  parameter int L1_IDX_W = 12,
  parameter int L2_IDX_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] va_i,
  input logic [VA_W-1:0] ttb_i,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [VA_W-1:0] mem_addr_o,
  input logic            mem_rsp_valid_i,
  input logic            done_o,
  input logic [1:0]      res_kind_o,
  input logic [VA_W-1:0] pa_o,
  input logic [VA_W-1:0] fault_va_o
);
  localparam int OFF_W = VA_W - L1_IDX_W;
  localparam int TTB_W = VA_W - L1_IDX_W - 2;

  logic [VA_W-1:0] cva_q, cttb_q;
  logic            l1_ph_q, rsp_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cva_q      <= '0;
      cttb_q     <= '0;
      l1_ph_q    <= 1'b0;
      rsp_pend_q <= 1'b0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        cva_q   <= va_i;
        cttb_q  <= ttb_i;
        l1_ph_q <= 1'b1;
      end else if (mem_req_valid_o && mem_req_ready_i) begin
        l1_ph_q <= 1'b0;
      end
      if (mem_req_valid_o && mem_req_ready_i) rsp_pend_q <= 1'b1;
      else if (mem_rsp_valid_i)               rsp_pend_q <= 1'b0;
    end
  end

  a_r1_l1_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && l1_ph_q |->
      mem_addr_o == {cttb_q[VA_W-1 -: TTB_W], cva_q[VA_W-1 -: L1_IDX_W], 2'b00});

  a_r7_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));

  a_r7_no_req_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_pend_q |-> !mem_req_valid_o);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  a_r8_ready_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_valid_o && !done_o);

  a_r2_section_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && res_kind_o == 2'd0 |-> pa_o[OFF_W-1:0] == cva_q[OFF_W-1:0]);

  a_r6_fault_va: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && res_kind_o == 2'd2 |-> fault_va_o == cva_q);

  a_r10_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> !mem_req_valid_o && !done_o);
endmodule

bind ttw_walker ttw_walker_chk #(.VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W)) u_chk (.*);

// File: tb/tb_ttw_walker.sv
module tb_ttw_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] va_i = '0, ttb_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o;
  logic [1:0]  res_kind_o;
  logic [31:0] pa_o;
  logic [1:0]  ap_o;
  logic [3:0]  dom_o;
  logic [1:0]  attr_o;
  logic [31:0] l2_desc_o;
  logic        fault_code_o;
  logic [31:0] fault_va_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ttw_walker dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_l1(input logic [31:0] ttb, input logic [31:0] va);
    return {ttb[31:14], va[31:20], 2'b00};
  endfunction
  function automatic logic [31:0] exp_l2(input logic [31:0] d, input logic [31:0] va);
    return {d[31:10], va[19:12], 2'b00};
  endfunction

  task automatic wait_req();
    int guard = 0;
    while (!mem_req_valid_o && guard < 50) begin
      @(negedge clk_i);
      guard++;
    end
  endtask

  // one memory phase: check address, stall, accept, respond after lat cycles
  task automatic mem_phase(input logic [31:0] addr, input string req, input logic [31:0] data,
                           input int stall, input int lat);
    wait_req();
    chk(mem_req_valid_o === 1'b1, "R7", {31'd0, mem_req_valid_o}, 32'd1);
    chk(mem_addr_o === addr, req, mem_addr_o, addr);
    repeat (stall) @(negedge clk_i);
    chk(mem_req_valid_o === 1'b1 && mem_addr_o === addr, "R7", mem_addr_o, addr);
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    repeat (lat) begin
      chk(mem_req_valid_o === 1'b0, "R7", {31'd0, mem_req_valid_o}, 32'd0);
      @(negedge clk_i);
    end
    mem_rsp_valid_i = 1'b1;
    mem_rdata_i     = data;
    req_valid_i     = 1'b0;
    va_i            = '0;
    @(negedge clk_i);
    mem_rsp_valid_i = 1'b0;
    mem_rdata_i     = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] ttb, input logic [31:0] d1,
                      input logic [31:0] d2, input bit intrude);
    int stall = $urandom_range(0, 3);
    int lat   = $urandom_range(1, 3);
    chk(req_ready_o === 1'b1, "R8", {31'd0, req_ready_o}, 32'd1);
    req_valid_i = 1'b1; va_i = va; ttb_i = ttb;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (intrude) begin
      req_valid_i = 1'b1; va_i = ~va; ttb_i = ~ttb;
      chk(req_ready_o === 1'b0, "R8", {31'd0, req_ready_o}, 32'd0);
    end
    mem_phase(exp_l1(ttb, va), "R1", d1, stall, lat);
    if (d1[1:0] == 2'b01) begin
      chk(done_o === 1'b0, "R4", {31'd0, done_o}, 32'd0);
      mem_phase(exp_l2(d1, va), "R4", d2, $urandom_range(0, 2), $urandom_range(1, 3));
    end
    chk(done_o === 1'b1, "R9", {31'd0, done_o}, 32'd1);
    chk(mem_req_valid_o === 1'b0, "R6", {31'd0, mem_req_valid_o}, 32'd0);
    unique case (d1[1:0])
      2'b10: begin
        chk(res_kind_o === 2'd0, "R2", {30'd0, res_kind_o}, 32'd0);
        chk(pa_o === {d1[31:20], va[19:0]}, "R2", pa_o, {d1[31:20], va[19:0]});
        chk(ap_o === d1[11:10], "R3", {30'd0, ap_o}, {30'd0, d1[11:10]});
        chk(dom_o === d1[8:5], "R3", {28'd0, dom_o}, {28'd0, d1[8:5]});
        chk(attr_o === d1[3:2], "R3", {30'd0, attr_o}, {30'd0, d1[3:2]});
      end
      2'b01: begin
        chk(res_kind_o === 2'd1, "R5", {30'd0, res_kind_o}, 32'd1);
        chk(l2_desc_o === d2, "R5", l2_desc_o, d2);
        chk(dom_o === d1[8:5], "R5", {28'd0, dom_o}, {28'd0, d1[8:5]});
      end
      default: begin
        chk(res_kind_o === 2'd2, "R6", {30'd0, res_kind_o}, 32'd2);
        chk(fault_code_o === (d1[1:0] == 2'b11), "R6", {31'd0, fault_code_o},
            {31'd0, d1[1:0] == 2'b11});
        chk(fault_va_o === va, "R6", fault_va_o, va);
      end
    endcase
    if (intrude) chk(fault_va_o === va, "R8", fault_va_o, va);
    @(negedge clk_i);
    chk(done_o === 1'b0 && req_ready_o === 1'b1, "R9", {30'd0, done_o, req_ready_o}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(req_ready_o === 1'b1 && mem_req_valid_o === 1'b0 && done_o === 1'b0, "R10",
        {29'd0, req_ready_o, mem_req_valid_o, done_o}, 32'd4);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed corners
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFF0_0DEE, 32'h0, 1'b0);
    walk(32'h0000_0000, 32'h0000_0000, 32'h0000_0002, 32'h0, 1'b0);
    walk(32'h1234_5678, 32'hA000_4000, 32'hCAFE_BC21, 32'h1357_9BDF, 1'b0);
    walk(32'hFFFF_F000, 32'hFFFF_C000, 32'hFFFF_FC01, 32'hFFFF_FFFF, 1'b0);
    walk(32'h8765_4321, 32'h0001_0000, 32'hDEAD_BEE0, 32'h0, 1'b0);
    walk(32'h8765_4321, 32'h0001_0000, 32'hDEAD_BEE3, 32'h0, 1'b0);
    walk(32'h0ABC_DEF0, 32'h5555_8000, 32'h1111_1112, 32'h0, 1'b1);
    walk(32'h0ABC_DEF0, 32'h5555_8000, 32'h2222_2221, 32'h3333_3333, 1'b1);

    // reset in mid-walk (R10)
    req_valid_i = 1'b1; va_i = 32'h4000_0000; ttb_i = 32'h0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    wait_req();
    mem_req_ready_i = 1'b1;
    @(negedge clk_i);
    mem_req_ready_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(mem_req_valid_o === 1'b0 && req_ready_o === 1'b1 && done_o === 1'b0, "R10",
        {29'd0, req_ready_o, mem_req_valid_o, done_o}, 32'd4);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_req_valid_o === 1'b0 && req_ready_o === 1'b1, "R10",
        {30'd0, req_ready_o, mem_req_valid_o}, 32'd2);
    walk(32'h4000_0000, 32'h0000_4000, 32'h0030_0C12, 32'h0, 1'b0);

    // random walks over all descriptor types
    for (int i = 0; i < 60; i++) begin
      logic [31:0] d1 = $urandom;
      d1[1:0] = 2'($urandom_range(0, 3));
      walk($urandom, $urandom, d1, $urandom, 1'($urandom_range(0, 1)));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule